// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block works out, from one request, both the byte address used for a memory access and the value that is written back to the base register. The base comes from a register. The offset is either a 12-bit unsigned constant or an index register shifted left by a 0 to 31 bit amount, so a word index can be scaled to a byte offset by shifting it by two. A direction bit chooses whether the offset is added to the base or subtracted from it. A single adder result serves both outputs. In pre-indexed form the sum is the access address. In post-indexed form the untouched base is the access address and the sum becomes the new base.

A small sequencer accepts a request only while it is idle. In the next cycle it presents the access address for exactly one cycle. If a base update is due, it then presents the new base with a one-cycle writeback strobe in the cycle after that. When no update is due it returns straight to idle. The register file and the memory sit outside this block.

Top module: `ldst_addr_gen`

## Requirements
- R1: After reset, reqReady is 1, accessValid is 0 and wbEn is 0.
- R2: With useIdx=0 the offset is immOffset zero-extended to 32 bits.
- R3: With useIdx=1 the offset is idxVal shifted left by shiftAmt (0 to 31). Bits shifted past bit 31 are lost.
- R4: addUp=1 forms base+offset and addUp=0 forms base-offset, both modulo 2^32.
- R5: With preIndex=1 and wbReq=1, effAddr is the sum. The following cycle carries wbEn=1 with newBase equal to the sum.
- R6: With preIndex=0 (post-indexed), effAddr is the unmodified base. A writeback of newBase equal to the sum always follows, whatever wbReq is.
- R7: With preIndex=1 and wbReq=0, effAddr is the sum. No writeback pulse follows, and the block is ready again in the next cycle.
- R8: A request sampled with reqValid=1 and reqReady=1 at a clock edge gives accessValid=1 for exactly the next cycle. Any writeback pulse lasts exactly one cycle and comes right after it.
- R9: reqReady is 0 while an access or writeback is in progress. A reqValid seen while reqReady=0 starts nothing and does not change the results of the operation in progress.
- R10: accessValid and wbEn are never high in the same cycle. effAddr reads 0 outside the access cycle, and newBase reads 0 outside the writeback cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block is idle and takes a request |
| baseVal | input | 32 | Base register value |
| immOffset | input | 12 | Unsigned immediate offset |
| idxVal | input | 32 | Index register value |
| useIdx | input | 1 | 1: use the shifted index, 0: use the immediate |
| shiftAmt | input | 5 | Left shift applied to idxVal |
| addUp | input | 1 | 1: add the offset, 0: subtract it |
| preIndex | input | 1 | 1: access at the sum, 0: access at the base |
| wbReq | input | 1 | Request a base update in pre-indexed form |
| accessValid | output | 1 | effAddr is valid this cycle |
| effAddr | output | 32 | Effective byte address |
| wbEn | output | 1 | Writeback strobe |
| newBase | output | 32 | Updated base value |

## Verification
The assertions check the handshake timing on every cycle: an accepted request leads to one access cycle, a writeback is always preceded by an access, the strobes never overlap, and the block reports busy while either strobe is high. Only the bench scenarios can show the arithmetic and the mode choice. These cover immediate versus shifted index offsets, subtraction that wraps below zero, shifts that discard high bits, the absence of a writeback in plain offset form, forced writeback in post-indexed form, and requests dropped while the block is busy.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  localparam int ADDR_W = 32;
  localparam int IMM_W  = 12;
  localparam int SH_W   = $clog2(ADDR_W);

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_ACCESS    = 2'd1,
    ST_WRITEBACK = 2'd2
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic showAddr;
    logic showWb;
  } lsagStrobe_t;
endpackage

// File: rtl/lsag_offset.sv
module lsag_offset #(
  parameter int AW = 32,
  parameter int IW = 12,
  parameter int SW = 5
) (
  input  logic          useIdx,
  input  logic [IW-1:0] immOffset,
  input  logic [AW-1:0] idxVal,
  input  logic [SW-1:0] shiftAmt,
  output logic [AW-1:0] offsetVal
);
  localparam int PAD_W = AW - IW;

  logic [AW-1:0] immExt;
  logic [AW-1:0] idxScaled;

  generate
    if (PAD_W > 0) begin : g_pad
      assign immExt = {{PAD_W{1'b0}}, immOffset};
    end else begin : g_nopad
      assign immExt = immOffset[AW-1:0];
    end
  endgenerate

  assign idxScaled = idxVal << shiftAmt;
  assign offsetVal = useIdx ? idxScaled : immExt;
endmodule

// File: rtl/lsag_datapath.sv
module lsag_datapath
  import lsag_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int IW = IMM_W,
  parameter int SW = SH_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  lsagStrobe_t   strobe,
  input  logic [AW-1:0] baseVal,
  input  logic [IW-1:0] immOffset,
  input  logic [AW-1:0] idxVal,
  input  logic          useIdx,
  input  logic [SW-1:0] shiftAmt,
  input  logic          addUp,
  input  logic          preIndex,
  input  logic          wbReq,
  output logic          wbNeeded,
  output logic [AW-1:0] effAddr,
  output logic [AW-1:0] newBase
);
  logic [AW-1:0] baseQ;
  logic [AW-1:0] offsetQ;
  logic          upQ;
  logic          preQ;
  logic          wbReqQ;
  logic [AW-1:0] offsetNow;
  logic [AW-1:0] sumVal;

  lsag_offset #(.AW(AW), .IW(IW), .SW(SW)) u_offset (
    .useIdx    (useIdx),
    .immOffset (immOffset),
    .idxVal    (idxVal),
    .shiftAmt  (shiftAmt),
    .offsetVal (offsetNow)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ   <= '0;
      offsetQ <= '0;
      upQ     <= 1'b1;
      preQ    <= 1'b1;
      wbReqQ  <= 1'b0;
    end else if (strobe.capture) begin
      baseQ   <= baseVal;
      offsetQ <= offsetNow;
      upQ     <= addUp;
      preQ    <= preIndex;
      wbReqQ  <= wbReq;
    end
  end

  assign sumVal   = upQ ? (baseQ + offsetQ) : (baseQ - offsetQ);
  assign wbNeeded = !preQ || wbReqQ;
  assign effAddr  = strobe.showAddr ? (preQ ? sumVal : baseQ) : '0;
  assign newBase  = strobe.showWb ? sumVal : '0;
endmodule

// File: rtl/lsag_control.sv
module lsag_control
  import lsag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        wbNeeded,
  output lsagStrobe_t strobe,
  output logic        reqReady,
  output logic        accessValid,
  output logic        wbEn
);
  seqState_t state;
  seqState_t stateNxt;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE:      if (reqValid) stateNxt = ST_ACCESS;
      ST_ACCESS:    stateNxt = wbNeeded ? ST_WRITEBACK : ST_IDLE;
      ST_WRITEBACK: stateNxt = ST_IDLE;
      default:      stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign reqReady        = (state == ST_IDLE);
  assign accessValid     = (state == ST_ACCESS);
  assign wbEn            = (state == ST_WRITEBACK);
  assign strobe.capture  = reqReady && reqValid;
  assign strobe.showAddr = accessValid;
  assign strobe.showWb   = wbEn;
endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
  import lsag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [IMM_W-1:0]  immOffset,
  input  logic [ADDR_W-1:0] idxVal,
  input  logic              useIdx,
  input  logic [SH_W-1:0]   shiftAmt,
  input  logic              addUp,
  input  logic              preIndex,
  input  logic              wbReq,
  output logic              accessValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic              wbEn,
  output logic [ADDR_W-1:0] newBase
);
  lsagStrobe_t strobe;
  logic        wbNeeded;

  lsag_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .wbNeeded    (wbNeeded),
    .strobe      (strobe),
    .reqReady    (reqReady),
    .accessValid (accessValid),
    .wbEn        (wbEn)
  );

  lsag_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .baseVal   (baseVal),
    .immOffset (immOffset),
    .idxVal    (idxVal),
    .useIdx    (useIdx),
    .shiftAmt  (shiftAmt),
    .addUp     (addUp),
    .preIndex  (preIndex),
    .wbReq     (wbReq),
    .wbNeeded  (wbNeeded),
    .effAddr   (effAddr),
    .newBase   (newBase)
  );
endmodule

// File: rtl/ldst_addr_gen_chk.sv
module ldst_addr_gen_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic accessValid,
  input logic wbEn
);
  // R8: an accepted request is followed by an access cycle
  a_r8_accept_leads_access: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> accessValid);
  // R8: the access strobe lasts a single cycle
  a_r8_access_single: assert property (@(posedge clk) disable iff (!rstN)
    accessValid |=> !accessValid);
  // R8: writeback comes only directly after an access and lasts one cycle
  a_r8_wb_after_access: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> $past(accessValid));
  a_r8_wb_single: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |=> !wbEn);
  // R10: strobes never overlap
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(accessValid && wbEn));
  // R9: busy while either strobe is high
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (accessValid || wbEn) |-> !reqReady);
endmodule

bind ldst_addr_gen ldst_addr_gen_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .accessValid (accessValid),
  .wbEn        (wbEn)
);

// File: tb/sim_ldst_addr_gen.sv
module sim_ldst_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] baseVal = '0;
  logic [11:0] immOffset = '0;
  logic [31:0] idxVal = '0;
  logic        useIdx = 1'b0;
  logic [4:0]  shiftAmt = '0;
  logic        addUp = 1'b1;
  logic        preIndex = 1'b1;
  logic        wbReq = 1'b0;
  logic        accessValid;
  logic [31:0] effAddr;
  logic        wbEn;
  logic [31:0] newBase;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_addr_gen u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .baseVal(baseVal), .immOffset(immOffset), .idxVal(idxVal),
    .useIdx(useIdx), .shiftAmt(shiftAmt), .addUp(addUp),
    .preIndex(preIndex), .wbReq(wbReq), .accessValid(accessValid),
    .effAddr(effAddr), .wbEn(wbEn), .newBase(newBase)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelSum(input logic [31:0] b, input logic [11:0] imm,
      input logic [31:0] idx, input logic ui, input logic [4:0] sh, input logic up);
    logic [31:0] off;
    off = ui ? (idx << sh) : {20'h0, imm};
    return up ? b + off : b - off;
  endfunction

  task automatic runOp(input string tag, input logic [31:0] b, input logic [11:0] imm,
      input logic [31:0] idx, input logic ui, input logic [4:0] sh, input logic up,
      input logic pre, input logic wr);
    logic [31:0] s;
    logic expWb;
    s = modelSum(b, imm, idx, ui, sh, up);
    expWb = !pre || wr;
    @(negedge clk);
    baseVal = b; immOffset = imm; idxVal = idx; useIdx = ui;
    shiftAmt = sh; addUp = up; preIndex = pre; wbReq = wr; reqValid = 1'b1;
    check({tag, " R9 ready before request"}, {31'b0, reqReady}, 32'd1);
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " R8 access strobe"}, {31'b0, accessValid}, 32'd1);
    check({tag, " R10 no wb in access cycle"}, {31'b0, wbEn}, 32'd0);
    check({tag, pre ? " R5/R7 addr is sum" : " R6 addr is base"}, effAddr, pre ? s : b);
    @(negedge clk);
    check({tag, " R8 access ends"}, {31'b0, accessValid}, 32'd0);
    check({tag, expWb ? " R5/R6 wb pulse" : " R7 no wb pulse"}, {31'b0, wbEn}, {31'b0, expWb});
    check({tag, " R5/R6 new base"}, newBase, expWb ? s : 32'd0);
    check({tag, " R7/R9 ready"}, {31'b0, reqReady}, {31'b0, !expWb});
    if (expWb) begin
      @(negedge clk);
      check({tag, " R8 wb ends"}, {31'b0, wbEn}, 32'd0);
      check({tag, " R9 ready after wb"}, {31'b0, reqReady}, 32'd1);
    end
  endtask

  task automatic testReset();
    check("R1 ready", {31'b0, reqReady}, 32'd1);
    check("R1 accessValid", {31'b0, accessValid}, 32'd0);
    check("R1 wbEn", {31'b0, wbEn}, 32'd0);
  endtask

  task automatic testBusyIgnore();
    @(negedge clk);
    baseVal = 32'h0000_1000; immOffset = 12'h010; useIdx = 1'b0;
    addUp = 1'b1; preIndex = 1'b0; wbReq = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    check("R9 busy access addr", effAddr, 32'h0000_1000);
    baseVal = 32'h5555_0000; immOffset = 12'hFFF; preIndex = 1'b1;
    @(negedge clk);
    check("R9 busy wb pulse", {31'b0, wbEn}, 32'd1);
    check("R9 busy wb value kept", newBase, 32'h0000_1010);
    reqValid = 1'b0;
    @(negedge clk);
    check("R9 no second access", {31'b0, accessValid}, 32'd0);
    check("R9 ready again", {31'b0, reqReady}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runOp("R2 imm pre wb", 32'h0000_2000, 12'hFFC, 32'h0, 1'b0, 5'd0, 1'b1, 1'b1, 1'b1);
    runOp("R4 sub wraps", 32'h0000_0010, 12'h020, 32'h0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b1);
    runOp("R3 word index", 32'h8000_0000, 12'h0, 32'h0000_0008, 1'b1, 5'd2, 1'b1, 1'b1, 1'b0);
    runOp("R3 shift 31", 32'h0000_0004, 12'h0, 32'h0000_0003, 1'b1, 5'd31, 1'b1, 1'b1, 1'b1);
    runOp("R4 add wraps", 32'hFFFF_FFF0, 12'h020, 32'h0, 1'b0, 5'd0, 1'b1, 1'b1, 1'b1);
    runOp("R6 post no req", 32'h0000_3000, 12'h004, 32'h0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0);
    runOp("R6 post idx down", 32'h0000_3000, 12'h0, 32'h0000_0010, 1'b1, 5'd4, 1'b0, 1'b0, 1'b1);
    runOp("R7 offset only", 32'h1234_5678, 12'h123, 32'h0, 1'b0, 5'd0, 1'b1, 1'b1, 1'b0);
    testBusyIgnore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule